// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead-Time Insertion

This block is one output channel of a timer array. It builds a center-aligned pulse by comparing a duty value against a shared time base. The time base counts up from 1 to a top value and then back down. It is an input to the block and is generated elsewhere. The rising side of each pulse comes from the duty match on the up-count, and the falling side comes from the duty match on the down-count. A channel-local counter then shifts one of those two edges by a dead-time count. A mode input selects the edge. On the leading edge the pulse gets shorter by the dead time. On the trailing edge it gets longer by the dead time.

Software writes the duty and dead-time values into shadow inputs. The block copies them into working registers only on the tick where the time base reads 1, which is the cycle boundary. A write during one PWM cycle therefore takes effect in the next cycle and never cuts a pulse in the middle. The state of the block changes only on prescaler ticks. These ticks must be the same ticks that advance the time base, so that duty and dead time are counted on the same scale.

Top module: `cpwm_center_dt`

## Requirements
- R1: The pin equals `pol` while the channel is inactive, including during and right after reset, and equals the complement of `pol` while active. A change of `pol` reaches the pin in the same cycle.
- R2: On a tick, the time base counts as rising when it reads 1 or reads more than the value seen on the previous tick. Otherwise it counts as falling. A duty match is an up-match or a down-match according to this direction.
- R3: With `lead_edge`=1, the output becomes active `dead` ticks after the up-match and inactive on the down-match tick. If the delayed edge would land on or after the down-match, the cycle has no pulse at all.
- R4: With `lead_edge`=0, the output becomes active on the up-match tick and inactive `dead` ticks after the down-match.
- R5: In a cycle where `tick` is 0, neither the pin nor any internal state changes, apart from the direct effect of `pol`.
- R6: The working duty and dead-time values load from `sh_duty` and `sh_dead` only on a tick where `tb_val` equals 1, and they take effect from that tick on. Shadow writes at any other time have no effect until the next boundary.
- R7: A dead time of 0 makes both edges follow the duty matches with no delay, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler tick, shared with the time base |
| tb_val | input | DW | Up/down time-base value |
| sh_duty | input | DW | Shadow duty value |
| sh_dead | input | TW | Shadow dead-time value, in ticks |
| lead_edge | input | 1 | 1: delay the leading edge, 0: delay the trailing edge |
| pol | input | 1 | Inactive pin level |
| pin | output | 1 | PWM output |

## Verification
Some rules are checked on every clock. The state is checked to stay frozen on tick-less cycles. The working registers are checked to reload only at the boundary. A down-match must end the pulse at once in leading mode, and an up-match must start it at once in trailing mode. Other behaviour can only be seen over whole scenarios. This covers the exact position of the delayed edge, a pulse that vanishes when the dead time swallows it, and a shadow write made in mid-cycle that is deferred to the next cycle. The bench covers these with randomized time-base tops, gaps between ticks, mode and polarity changes, and directed cycles with zero and oversized dead times.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
   typedef enum logic {
      DT_TRAIL = 1'b0,
      DT_LEAD  = 1'b1
   } dt_edge_e;
endpackage

// File: rtl/cpwm_tb_decode.sv
module cpwm_tb_decode #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [DW-1:0] tb_val,
   input  logic [DW-1:0] eff_duty,
   output logic          boundary,
   output logic          up_match,
   output logic          dn_match
);
   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] prev_q;
   logic          rising;
   logic          hit;

   assign boundary = (tb_val == ONE);
   assign rising   = boundary || (tb_val > prev_q);
   assign hit      = tick && (tb_val == eff_duty);
   assign up_match = hit && rising;
   assign dn_match = hit && !rising;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= '0;
      else if (tick) prev_q <= tb_val;
   end
endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
   parameter int DW = 8,
   parameter int TW = 8,
   parameter bit BYPASS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] sh_duty,
   input  logic [TW-1:0] sh_dead,
   output logic [DW-1:0] act_duty,
   output logic [TW-1:0] act_dead,
   output logic [DW-1:0] eff_duty,
   output logic [TW-1:0] eff_dead
);
   generate
      if (BYPASS) begin : g_direct
         assign act_duty = sh_duty;
         assign act_dead = sh_dead;
         assign eff_duty = sh_duty;
         assign eff_dead = sh_dead;
      end else begin : g_buffered
         logic [DW-1:0] duty_q;
         logic [TW-1:0] dead_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               duty_q <= '0;
               dead_q <= '0;
            end else if (load) begin
               duty_q <= sh_duty;
               dead_q <= sh_dead;
            end
         end
         assign act_duty = duty_q;
         assign act_dead = dead_q;
         assign eff_duty = load ? sh_duty : duty_q;
         assign eff_dead = load ? sh_dead : dead_q;
      end
   endgenerate
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic          cancel,
   input  logic [TW-1:0] dead,
   output logic          fire,
   output logic          running
);
   localparam logic [TW-1:0] ZERO = '0;
   localparam logic [TW-1:0] ONE  = TW'(1);

   logic [TW-1:0] cnt_q;
   logic          run_q;
   logic          reached;

   assign reached = run_q && tick && (cnt_q >= dead);
   assign fire    = (start && (dead == ZERO)) || reached;
   assign running = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (cancel) begin
         run_q <= 1'b0;
      end else if (start) begin
         run_q <= (dead != ZERO);
         cnt_q <= ONE;
      end else if (run_q && tick) begin
         if (cnt_q >= dead) run_q <= 1'b0;
         else               cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/cpwm_center_dt.sv
module cpwm_center_dt
   import cpwm_pkg::*;
#(
   parameter int DW     = 8,
   parameter int TW     = 8,
   parameter bit BYPASS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [DW-1:0] tb_val,
   input  logic [DW-1:0] sh_duty,
   input  logic [TW-1:0] sh_dead,
   input  logic          lead_edge,
   input  logic          pol,
   output logic          pin
);
   initial begin
      assert (DW >= 2) else $error("cpwm_center_dt: DW must be at least 2");
      assert (TW >= 1) else $error("cpwm_center_dt: TW must be at least 1");
   end

   dt_edge_e      mode;
   logic          boundary, up_match, dn_match;
   logic [DW-1:0] act_duty, eff_duty;
   logic [TW-1:0] act_dead, eff_dead;
   logic          start, cancel, fire, running;
   logic          on_q;

   assign mode = dt_edge_e'(lead_edge);

   cpwm_shadow #(.DW(DW), .TW(TW), .BYPASS(BYPASS)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(tick && boundary),
      .sh_duty(sh_duty), .sh_dead(sh_dead),
      .act_duty(act_duty), .act_dead(act_dead),
      .eff_duty(eff_duty), .eff_dead(eff_dead)
   );

   cpwm_tb_decode #(.DW(DW)) u_decode (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tb_val(tb_val),
      .eff_duty(eff_duty), .boundary(boundary),
      .up_match(up_match), .dn_match(dn_match)
   );

   assign start  = (mode == DT_LEAD) ? up_match : dn_match;
   assign cancel = (mode == DT_LEAD) ? dn_match : up_match;

   cpwm_deadtime #(.TW(TW)) u_dead (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
      .cancel(cancel), .dead(eff_dead), .fire(fire), .running(running)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q <= 1'b0;
      end else if (tick) begin
         if (mode == DT_LEAD) begin
            if (dn_match)  on_q <= 1'b0;
            else if (fire) on_q <= 1'b1;
         end else begin
            if (up_match)  on_q <= 1'b1;
            else if (fire) on_q <= 1'b0;
         end
      end
   end

   assign pin = on_q ? ~pol : pol;
endmodule

// File: rtl/cpwm_center_dt_chk.sv
module cpwm_center_dt_chk #(
   parameter int DW = 8,
   parameter int TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic [DW-1:0] tb_val,
   input logic          lead_edge,
   input logic          up_match,
   input logic          dn_match,
   input logic          on_q,
   input logic          running,
   input logic [DW-1:0] act_duty,
   input logic [TW-1:0] act_dead
);
   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(on_q) && $stable(running));

   p_load_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && tb_val == DW'(1)) |=> $stable(act_duty) && $stable(act_dead));

   p_lead_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_edge && dn_match) |=> !on_q);

   p_trail_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lead_edge && up_match) |=> on_q);

   p_one_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_match && dn_match));
endmodule

bind cpwm_center_dt cpwm_center_dt_chk #(.DW(DW), .TW(TW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .tb_val(tb_val),
   .lead_edge(lead_edge), .up_match(up_match), .dn_match(dn_match),
   .on_q(on_q), .running(running), .act_duty(act_duty), .act_dead(act_dead)
);

// File: tb/cpwm_center_dt_bench.sv
module cpwm_center_dt_bench;
   localparam int DW = 8;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [DW-1:0] tb_val = '0;
   logic [DW-1:0] sh_duty = '0;
   logic [TW-1:0] sh_dead = '0;
   logic          lead_edge = 1'b0;
   logic          pol = 1'b1;
   logic          pin;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cpwm_center_dt #(.DW(DW), .TW(TW)) u_cpwm_center_dt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tb_val(tb_val),
      .sh_duty(sh_duty), .sh_dead(sh_dead), .lead_edge(lead_edge),
      .pol(pol), .pin(pin)
   );

   task automatic chk(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: pin=%b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   // Expected active state after tick index i of a cycle with top tp.
   function automatic bit exp_on(int i, int tp, int d, int dt, bit lead);
      int up_i = d - 1;
      int dn_i = 2 * tp - 1 - d;
      if (lead) return (up_i + dt < dn_i) && (i >= up_i + dt) && (i < dn_i);
      return (i >= up_i) && (i < dn_i + dt);
   endfunction

   function automatic int tb_at(int i, int tp);
      return (i < tp) ? i + 1 : 2 * tp - 1 - i;
   endfunction

   task automatic one_tick(input int v, input bit exp, input string req);
      int gaps = $urandom % 3;
      logic held;
      @(negedge clk);
      held = pin;
      for (int g = 0; g < gaps; g++) begin
         tick = 1'b0;
         tb_val = DW'($urandom);
         @(negedge clk);
         chk(pin, held, "R5");
      end
      tick = 1'b1;
      tb_val = DW'(v);
      @(negedge clk);
      tick = 1'b0;
      chk(pin, exp ? ~pol : pol, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int tp, d, dt, ntp, nd, ndt;
      bit lead, nlead;
      string tag;
      void'($urandom(32'd4711));

      pol = 1'b1;
      repeat (3) @(negedge clk);
      chk(pin, 1'b1, "R1 reset pol=1");
      pol = 1'b0;
      #1 chk(pin, 1'b0, "R1 reset pol=0");
      rst_n = 1'b1;
      @(negedge clk);
      chk(pin, 1'b0, "R1 after reset");

      // first cycle: leading edge, zero dead time
      tp = 8; d = 3; dt = 0; lead = 1'b1;
      sh_duty = DW'(d); sh_dead = TW'(dt); lead_edge = lead;

      for (int p = 0; p < 40; p++) begin
         // directed picks for the next cycle, then random
         case (p)
            0: begin ntp = 8;  nd = 4; ndt = 0;  nlead = 1'b0; end
            1: begin ntp = 6;  nd = 3; ndt = 20; nlead = 1'b1; end
            2: begin ntp = 10; nd = 7; ndt = 5;  nlead = 1'b0; end
            3: begin ntp = 12; nd = 2; ndt = 3;  nlead = 1'b1; end
            default: begin
               ntp   = 4 + ($urandom % 13);
               nd    = 2 + ($urandom % (ntp - 2));
               nlead = 1'($urandom);
               ndt   = nlead ? ($urandom % (2 * ntp)) : ($urandom % (nd - 1));
            end
         endcase
         if (p % 5 == 4) pol = ~pol;
         for (int i = 0; i < 2 * tp - 2; i++) begin
            if (i == 0)                   tag = "R6 boundary";
            else if (dt == 0)             tag = "R7 zero dead time";
            else if (i >= tp)             tag = lead ? "R2 R3 falling" : "R2 R4 falling";
            else                          tag = lead ? "R3 leading" : "R4 trailing";
            one_tick(tb_at(i, tp), exp_on(i, tp, d, dt, lead), tag);
            if (i == tp - 1) begin
               // mid-cycle shadow write must wait for the next boundary
               sh_duty = DW'(nd);
               sh_dead = TW'(ndt);
            end
         end
         tp = ntp; d = nd; dt = ndt; lead = nlead;
         lead_edge = lead;
      end

      // immediate polarity effect while idle
      @(negedge clk);
      pol = ~pol;
      #1 chk(pin, pol, "R1 polarity flip");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule